// File: doc/BRIEF.md
# Serial Management Target with Control and Status Registers

This block is the target end of a two-wire management bus. It watches already-synchronized clock and data lines, finds START and STOP conditions and shifts in bytes. It answers only when the host calls its own 7-bit device address. For those frames it drives an acknowledge pulse low on the data line through a pull-low enable. The first byte after a write-direction address sets an internal register pointer, and any bytes after that are written to the register the pointer selects. A read-direction address, normally sent after a repeated START, returns the selected register most significant bit first. The pointer does not advance on its own, so a host that acknowledges and keeps clocking receives the same register again.

Three control registers are writable. Each one holds a few live fields next to reserved fields that always keep a fixed pattern. The live fields drive the block's control outputs directly. A fourth register is read-only and carries a 4-bit acquisition status code taken from an input port. A START or STOP that arrives in the middle of a byte cancels whatever transfer is in progress.

Top module: `smb_tgt_regbank`

## Requirements
- R1: The target acknowledges only the device address 57h. That is 8'hAE on the bus for a write and 8'hAF for a read. For any other address it never pulls SDA low until the next START or STOP, and any bytes that follow in that frame change no register.
- R2: The target pulls SDA low during the ninth clock after the matching address byte, after the register-pointer byte, and after every data byte it is written.
- R3: Register 00h keeps written bits 7:6 (rate select), bit 2 (bypass), bit 1 (mute) and bit 0 (clock-output enable). Bits 5:3 always read 000, and the reset value is 00h.
- R4: In register 0Eh, bits 3:2 hold the loop charge-pump code. Bits 7:4 always read 0001 and bits 1:0 always read 11, so the reset value is 13h.
- R5: In register 10h, bit 2 powers down the primary driver and bit 1 powers down the secondary driver. Bits 7:3 always read 10000 and bit 0 always reads 0, so the reset value is 80h.
- R6: Register 32h reads as {statusCode, 4'b0000}. A write to it is acknowledged and changes nothing.
- R7: Reading any address other than 00h, 0Eh, 10h or 32h returns 00h. A write to such an address is acknowledged and leaves all registers unchanged.
- R8: A read returns the register the pointer selects, MSB first. The pointer keeps its value across STOP and START. A host ACK after a read byte returns the same register again, and a host NACK ends the transfer with SDA released.
- R9: A START or STOP that arrives in the middle of a byte abandons that byte and restarts bit counting. After a STOP, SDA is released. The target never changes its SDA drive while SCL stays high.
- R10: The control outputs always equal the live fields of registers 00h, 0Eh and 10h. They change only when a data byte is written to one of those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, well above the bus bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level |
| statusCode | input | 4 | Acquisition status shown in register 32h bits 7:4 |
| sdaPullLow | output | 1 | When high, the open-drain data line is pulled low |
| rateSel | output | 2 | Rate-select field of register 00h |
| bypassForce | output | 1 | Bypass field of register 00h |
| muteOut | output | 1 | Mute field of register 00h |
| clkOutEn | output | 1 | Clock-output enable field of register 00h |
| pumpCode | output | 2 | Charge-pump code of register 0Eh |
| priPowerDown | output | 1 | Primary-driver power-down field of register 10h |
| secPowerDown | output | 1 | Secondary-driver power-down field of register 10h |

## Verification
The bench builds the block with its default device address 57h and an 8-bit byte. With those values the full 7-bit address space can be swept, so every wrong address is shown to get no acknowledge. The sweep also covers every live-field combination of the three control registers while varying values are written into their reserved bits, and all sixteen status codes. With the same small configuration, an open-drain bus model is cheap enough to run directed frames for pointer retention, repeated reads and START or STOP aborts partway through a byte.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_REGPTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } linkState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadPtr;
    logic writeData;
    logic loadTx;
    logic shiftTx;
  } linkStrobe_t;

  localparam logic [BYTE_W-1:0] REG_BASIC  = 8'h00;
  localparam logic [BYTE_W-1:0] REG_LOOP   = 8'h0E;
  localparam logic [BYTE_W-1:0] REG_DRIVE  = 8'h10;
  localparam logic [BYTE_W-1:0] REG_STATUS = 8'h32;

  localparam logic [3:0] LOOP_FIX_HI  = 4'b0001;
  localparam logic [1:0] LOOP_FIX_LO  = 2'b11;
  localparam logic [4:0] DRIVE_FIX_HI = 5'b10000;

endpackage

// File: rtl/smb_tgt_ctrl.sv
module smb_tgt_ctrl
  import smb_tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrHit,
  input  logic        rwBit,
  input  logic        txMsb,
  output linkStrobe_t strb,
  output logic        sdaPullLow
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic             sclQ, sdaQ;
  linkState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackDrive, txActive, hostNack;
  logic             sclRise, sclFall, startDet, stopDet, inFrame;

  always_comb begin
    sclRise  = sclIn & ~sclQ;
    sclFall  = ~sclIn & sclQ;
    startDet = sclIn & sclQ & sdaQ & ~sdaIn;
    stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;
    inFrame  = (state == ST_DEVADDR) || (state == ST_REGPTR) ||
               (state == ST_WDATA) || (state == ST_RDATA);
    strb = '0;
    if (!startDet && !stopDet && inFrame) begin
      strb.shiftEn   = sclRise && (bitCnt < LAST_BIT);
      strb.loadPtr   = sclFall && (bitCnt == LAST_BIT) && (state == ST_REGPTR);
      strb.writeData = sclFall && (bitCnt == LAST_BIT) && (state == ST_WDATA);
      strb.loadTx    = sclFall && (bitCnt == ACK_BIT) &&
                       (((state == ST_DEVADDR) && addrHit && rwBit) ||
                        ((state == ST_RDATA) && !hostNack));
      strb.shiftTx   = sclFall && (state == ST_RDATA) &&
                       (bitCnt != '0) && (bitCnt < LAST_BIT);
    end
  end

  assign sdaPullLow = ackDrive | (txActive & ~txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      hostNack <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startDet) begin
        state    <= ST_DEVADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txActive <= 1'b0;
      end else if (stopDet) begin
        state    <= ST_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txActive <= 1'b0;
      end else if (inFrame) begin
        if (sclRise) begin
          if (bitCnt != ACK_BIT) bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == LAST_BIT) hostNack <= sdaIn;
        end
        if (sclFall) begin
          if (bitCnt == LAST_BIT) begin
            txActive <= 1'b0;
            if ((state == ST_DEVADDR) && !addrHit) state <= ST_SKIP;
            else if (state != ST_RDATA)            ackDrive <= 1'b1;
          end else if (bitCnt == ACK_BIT) begin
            bitCnt   <= '0;
            ackDrive <= 1'b0;
            case (state)
              ST_DEVADDR: begin
                state    <= rwBit ? ST_RDATA : ST_REGPTR;
                txActive <= rwBit;
              end
              ST_REGPTR: state <= ST_WDATA;
              ST_RDATA: begin
                if (hostNack) state    <= ST_SKIP;
                else          txActive <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R2: the acknowledge drive lives only in the ninth-clock window
  p_ack_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> ((bitCnt == LAST_BIT) || (bitCnt == ACK_BIT)));

  // R1: a frame addressed elsewhere never sees SDA pulled
  p_silent_on_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaPullLow);

  // R9: no SDA change while SCL is held high
  p_sda_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ && sclIn && !startDet && !stopDet) |=> $stable(sdaPullLow));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> ((state == ST_IDLE) && !sdaPullLow));

  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> ((state == ST_DEVADDR) && (bitCnt == '0)));

endmodule

// File: rtl/smb_tgt_regs.sv
module smb_tgt_regs
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h57
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaIn,
  input  linkStrobe_t strb,
  input  logic [3:0]  statusCode,
  output logic        addrHit,
  output logic        rwBit,
  output logic        txMsb,
  output logic [1:0]  rateSel,
  output logic        bypassForce,
  output logic        muteOut,
  output logic        clkOutEn,
  output logic [1:0]  pumpCode,
  output logic        priPowerDown,
  output logic        secPowerDown
);

  logic [BYTE_W-1:0] rxByte, txShift, regPtr, rdByte;
  logic [4:0]        basicLive;
  logic [1:0]        pumpLive, pdLive;

  assign addrHit = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign rwBit   = rxByte[0];
  assign txMsb   = txShift[BYTE_W-1];

  always_comb begin
    case (regPtr)
      REG_BASIC:  rdByte = {basicLive[4:3], 3'b000, basicLive[2:0]};
      REG_LOOP:   rdByte = {LOOP_FIX_HI, pumpLive, LOOP_FIX_LO};
      REG_DRIVE:  rdByte = {DRIVE_FIX_HI, pdLive, 1'b0};
      REG_STATUS: rdByte = {statusCode, 4'b0000};
      default:    rdByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      txShift   <= '0;
      regPtr    <= '0;
      basicLive <= '0;
      pumpLive  <= '0;
      pdLive    <= '0;
    end else begin
      if (strb.shiftEn) rxByte <= {rxByte[BYTE_W-2:0], sdaIn};
      if (strb.loadPtr) regPtr <= rxByte;
      if (strb.loadTx)       txShift <= rdByte;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.writeData) begin
        case (regPtr)
          REG_BASIC: basicLive <= {rxByte[7:6], rxByte[2:0]};
          REG_LOOP:  pumpLive  <= rxByte[3:2];
          REG_DRIVE: pdLive    <= rxByte[2:1];
          default: ;
        endcase
      end
    end
  end

  assign rateSel      = basicLive[4:3];
  assign bypassForce  = basicLive[2];
  assign muteOut      = basicLive[1];
  assign clkOutEn     = basicLive[0];
  assign pumpCode     = pumpLive;
  assign priPowerDown = pdLive[1];
  assign secPowerDown = pdLive[0];

  // R8: the pointer moves only on a register-pointer byte
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPtr |=> $stable(regPtr));

  // R10: control fields move only on a data-byte write
  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeData |=> $stable({basicLive, pumpLive, pdLive}));

  // R8: read shifter holds between bus clock falls
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTx && !strb.shiftTx) |=> $stable(txShift));

endmodule

// File: rtl/smb_tgt_regbank.sv
module smb_tgt_regbank
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h57
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [3:0] statusCode,
  output logic       sdaPullLow,
  output logic [1:0] rateSel,
  output logic       bypassForce,
  output logic       muteOut,
  output logic       clkOutEn,
  output logic [1:0] pumpCode,
  output logic       priPowerDown,
  output logic       secPowerDown
);

  linkStrobe_t strb;
  logic        addrHit, rwBit, txMsb;

  smb_tgt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .addrHit    (addrHit),
    .rwBit      (rwBit),
    .txMsb      (txMsb),
    .strb       (strb),
    .sdaPullLow (sdaPullLow)
  );

  smb_tgt_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .sdaIn        (sdaIn),
    .strb         (strb),
    .statusCode   (statusCode),
    .addrHit      (addrHit),
    .rwBit        (rwBit),
    .txMsb        (txMsb),
    .rateSel      (rateSel),
    .bypassForce  (bypassForce),
    .muteOut      (muteOut),
    .clkOutEn     (clkOutEn),
    .pumpCode     (pumpCode),
    .priPowerDown (priPowerDown),
    .secPowerDown (secPowerDown)
  );

endmodule

// File: tb/tb_smb_tgt_regbank.sv
module tb_smb_tgt_regbank;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       scl = 1'b1;
  logic       hostSda = 1'b1;
  logic [3:0] statusCode = 4'h0;
  logic       sdaLine;
  logic       sdaPullLow, bypassForce, muteOut, clkOutEn, priPowerDown, secPowerDown;
  logic [1:0] rateSel, pumpCode;

  assign sdaLine = hostSda & ~sdaPullLow;

  smb_tgt_regbank dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .statusCode(statusCode),
    .sdaPullLow(sdaPullLow), .rateSel(rateSel), .bypassForce(bypassForce),
    .muteOut(muteOut), .clkOutEn(clkOutEn), .pumpCode(pumpCode),
    .priPowerDown(priPowerDown), .secPowerDown(secPowerDown)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic hold();
    repeat (3) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; hold(); scl = 1'b1; hold(); hostSda = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic busStop();
    hostSda = 1'b0; hold(); scl = 1'b1; hold(); hostSda = 1'b1; hold();
  endtask

  task automatic busBit(logic b);
    hostSda = b; hold(); scl = 1'b1; hold(); scl = 1'b0; hold();
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) busBit(v[i]);
    hostSda = 1'b1; hold(); scl = 1'b1; hold();
    ack = ~sdaLine;
    scl = 1'b0; hold();
  endtask

  task automatic recvByte(logic hostAck, output logic [7:0] v);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl = 1'b1; hold(); v[i] = sdaLine; scl = 1'b0;
    end
    hold();
    busBit(~hostAck);
    hostSda = 1'b1;
  endtask

  task automatic regWrite(logic [7:0] ptr, logic [7:0] v, output logic ok);
    logic a1, a2, a3;
    busStart(); sendByte(8'hAE, a1); sendByte(ptr, a2); sendByte(v, a3); busStop();
    ok = a1 & a2 & a3;
  endtask

  task automatic regRead(logic [7:0] ptr, output logic [7:0] v, output logic ok);
    logic a1, a2, a3;
    busStart(); sendByte(8'hAE, a1); sendByte(ptr, a2);
    busStart(); sendByte(8'hAF, a3); recvByte(1'b0, v); busStop();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] rd, rd2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    hold();

    // reset state
    check("R9 idle release", sdaPullLow, 0);
    check("R10 reset outputs", {rateSel, bypassForce, muteOut, clkOutEn, pumpCode, priPowerDown, secPowerDown}, 0);
    regRead(8'h00, rd, ok); check("R3 reset value", rd, 8'h00); check("R2 read acks", ok, 1);
    regRead(8'h0E, rd, ok); check("R4 reset value", rd, 8'h13);
    regRead(8'h10, rd, ok); check("R5 reset value", rd, 8'h80);

    // R3 sweep: every live combination, reserved bits written with varying junk
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = {i[4:3], 3'(i * 5 + 1), i[2:0]};
      regWrite(8'h00, v, ok); check("R2 write acks", ok, 1);
      regRead(8'h00, rd, ok);
      check("R3 readback", rd, {v[7:6], 3'b000, v[2:0]});
      check("R10 basic outputs", {rateSel, bypassForce, muteOut, clkOutEn}, {v[7:6], v[2:0]});
    end

    // R4 sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h11) ^ 8'hC0;
      regWrite(8'h0E, v, ok); check("R2 write acks", ok, 1);
      regRead(8'h0E, rd, ok);
      check("R4 readback", rd, {4'b0001, v[3:2], 2'b11});
      check("R10 pump output", pumpCode, v[3:2]);
    end

    // R5 sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h11) ^ 8'h5A;
      regWrite(8'h10, v, ok); check("R2 write acks", ok, 1);
      regRead(8'h10, rd, ok);
      check("R5 readback", rd, {5'b10000, v[2:1], 1'b0});
      check("R10 power-down outputs", {priPowerDown, secPowerDown}, v[2:1]);
    end

    // R6 status sweep and ignored write
    for (int c = 0; c < 16; c++) begin
      statusCode = 4'(c);
      regRead(8'h32, rd, ok);
      check("R6 status read", rd, {4'(c), 4'b0000});
    end
    regWrite(8'h32, 8'hFF, ok); check("R6 write acked", ok, 1);
    statusCode = 4'h9;
    regRead(8'h32, rd, ok); check("R6 write discarded", rd, 8'h90);

    // known state for later comparisons
    regWrite(8'h00, 8'hC5, ok);
    regWrite(8'h0E, 8'h08, ok);
    regWrite(8'h10, 8'h04, ok);

    // R7 unmapped addresses
    foreach (rd2[k]) begin
      logic [7:0] p;
      p = 8'h01 + 8'(k * 37);
      if (p == 8'h00 || p == 8'h0E || p == 8'h10 || p == 8'h32) p = 8'hFF;
      regWrite(p, 8'hA5, ok); check("R7 unmapped write acked", ok, 1);
      regRead(p, rd, ok); check("R7 unmapped read", rd, 8'h00);
    end
    regRead(8'h00, rd, ok); check("R7 basic untouched", rd, 8'hC5);
    regRead(8'h0E, rd, ok); check("R7 loop untouched", rd, 8'h1B);
    regRead(8'h10, rd, ok); check("R7 drive untouched", rd, 8'h84);

    // R1 address sweep, write direction
    for (int adr = 0; adr < 128; adr++) begin
      busStart(); sendByte({7'(adr), 1'b0}, a); busStop();
      check("R1 address ack", a, (adr == 8'h57) ? 1 : 0);
    end
    busStart(); sendByte(8'hAD, a); busStop(); check("R1 read-direction miss", a, 0);
    busStart(); sendByte(8'hAC, a); check("R1 miss no ack", a, 0);
    sendByte(8'h00, a); check("R1 miss pointer no ack", a, 0);
    sendByte(8'h00, a); check("R1 miss data no ack", a, 0);
    busStop();
    regRead(8'h00, rd, ok); check("R1 miss leaves register", rd, 8'hC5);

    // R8 pointer retained, repeated read with host ACK
    busStart(); sendByte(8'hAE, a); sendByte(8'h0E, a); busStop();
    busStart(); sendByte(8'hAF, a); check("R8 direct read acked", a, 1);
    recvByte(1'b1, rd); recvByte(1'b0, rd2); busStop();
    check("R8 pointer retained", rd, 8'h1B);
    check("R8 no auto-increment", rd2, 8'h1B);
    check("R8 released after nack", sdaPullLow, 0);

    // R9 STOP mid data byte
    busStart(); sendByte(8'hAE, a); sendByte(8'h00, a);
    busBit(1'b0); busBit(1'b0); busBit(1'b1); busBit(1'b0);
    busStop();
    check("R9 released after stop", sdaPullLow, 0);
    regRead(8'h00, rd, ok); check("R9 stop abort keeps register", rd, 8'hC5);
    check("R10 outputs kept", {rateSel, bypassForce, muteOut, clkOutEn}, 5'b11101);

    // R9 START mid address byte, then a full write
    busStart(); busBit(1'b1); busBit(1'b0); busBit(1'b1);
    busStart(); sendByte(8'hAE, a); check("R9 restart address acked", a, 1);
    sendByte(8'h10, a); sendByte(8'h02, a); check("R9 restart data acked", a, 1);
    busStop();
    regRead(8'h10, rd, ok); check("R9 restart write applied", rd, 8'h82);

    done = 1;
    report();
  end

endmodule